// File: doc/BRIEF.md
# Overlay Memory Address Decoder

This block sits beside a DSP core and steers each 14-bit program-memory and data-memory access to its target. The target is on-chip RAM, one of two 8K external segments, or, for data only, a 32-word window of control registers. Two small overlay registers choose which segment fills the switchable 8K half of each space. Software writes them through one write strobe with a space select. Each register holds its value until it is written again. Nothing saves or restores it on its own.

A mode input sets the program space layout. With the input low, the lower half of program space is on-chip and the upper half is switchable. With the input high, the lower half is external and the upper half is on-chip, and the program overlay register must stay at zero. The decode is purely combinational from the addresses, the mode input and the register contents. A register write lands at the next clock edge. An overlay value the layout does not allow raises an error flag and keeps the affected access on chip.

Top module: `ovl_addr_decoder`

## Requirements
- R1: While reset is active (`rstN` low), both overlay registers clear to 0. After reset, program 0x2000 and data 0x0000 both decode as internal and `ovlErr` is 0.
- R2: With `compatMode`=0, program addresses 0x0000–0x1FFF assert `pmIntSel`. Program addresses 0x2000–0x3FFF assert `pmIntSel` when the program overlay register is 0 and `pmExtSel` when it is 1 or 2.
- R3: During an external access, the external address carries the core address bits 12:0 unchanged. Its bit 13 is 0 for overlay 1 (and for the compatibility-mode lower half) and 1 for overlay 2. When its space has no external access, the external address is 0.
- R4: Data addresses 0x2000–0x3FDF assert `dmIntSel`. Data addresses 0x3FE0–0x3FFF assert `dmRegSel` and not `dmIntSel`. Neither range is affected by the data overlay register.
- R5: Data addresses 0x0000–0x1FFF assert `dmIntSel` when the data overlay register is 0 and `dmExtSel` when it is 1 or 2.
- R6: With `compatMode`=1, program addresses 0x0000–0x1FFF assert `pmExtSel` with external bit 13 = 0. Program addresses 0x2000–0x3FFF assert `pmIntSel`. The program overlay register has no effect on this decode.
- R7: `ovlErr` is 1 in three cases: the data register holds 3, the program register holds 3, or the program register is nonzero while `compatMode`=1. In normal mode, an illegal program value sends 0x2000–0x3FFF to internal. A data value of 3 sends 0x0000–0x1FFF to internal.
- R8: A write (`ovlWrEn`=1; `ovlWrSel` 0 = program, 1 = data; value on `ovlWrData`) takes effect at the next rising clock edge. An access in the same cycle as the write decodes with the old value.
- R9: At most one select of each space is asserted at a time. All selects of a space are 0 while its request input is 0.
- R10: Writing one overlay register leaves the other register's value, and the decode that depends on it, unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| compatMode | input | 1 | Program layout select (1 = lower half external) |
| ovlWrEn | input | 1 | Overlay register write strobe |
| ovlWrSel | input | 1 | Write target: 0 program, 1 data |
| ovlWrData | input | 2 | Overlay value to write |
| pmReq | input | 1 | Program access active |
| pmAddr | input | 14 | Program address from core |
| dmReq | input | 1 | Data access active |
| dmAddr | input | 14 | Data address from core |
| pmIntSel | output | 1 | On-chip program RAM select |
| pmExtSel | output | 1 | External program chip-select |
| pmExtAddr | output | 14 | External program address |
| dmIntSel | output | 1 | On-chip data RAM select |
| dmRegSel | output | 1 | Control register window select |
| dmExtSel | output | 1 | External data chip-select |
| dmExtAddr | output | 14 | External data address |
| ovlErr | output | 1 | Illegal overlay setting |

## Verification
The assertions check the following on every cycle:
- exclusivity of selects and their silence without a request;
- the address ranges that may reach the external bus or the register window;
- the pass-through of the low address bits;
- the compatibility-mode lower half;
- the one-edge latency of a program write;
- the stability of the error flag when nothing writes.

The full mapping against every overlay value needs the bench's sweep of the boundary addresses under both layouts, and so does the choice of segment bit. So do three more behaviours: the old value being used in the write cycle, one register surviving a write to the other, and the restore on reset.

// File: rtl/ovl_dec_pkg.sv
package ovl_dec_pkg;

  // Overlay register encodings
  typedef enum logic [1:0] {
    OVL_INTERNAL = 2'd0,
    OVL_SEG_LO   = 2'd1,
    OVL_SEG_HI   = 2'd2,
    OVL_INVALID  = 2'd3
  } ovlSel_t;

  // Strobes from write control to datapath
  typedef struct packed {
    logic    pmWr;
    logic    dmWr;
    ovlSel_t val;
  } ovlStrobe_t;

endpackage

// File: rtl/ovl_wr_ctrl.sv
module ovl_wr_ctrl
  import ovl_dec_pkg::*;
(
  input  logic       ovlWrEn,
  input  logic       ovlWrSel,
  input  logic [1:0] ovlWrData,
  output ovlStrobe_t strobe
);

  always_comb begin
    strobe.pmWr = ovlWrEn && !ovlWrSel;
    strobe.dmWr = ovlWrEn && ovlWrSel;
    strobe.val  = ovlSel_t'(ovlWrData);
  end

endmodule

// File: rtl/ovl_decode_dp.sv
module ovl_decode_dp
  import ovl_dec_pkg::*;
#(
  parameter int ADDR_W    = 14,
  parameter int REG_WIN_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  ovlStrobe_t        strobe,
  input  logic              compatMode,
  input  logic              pmReq,
  input  logic [ADDR_W-1:0] pmAddr,
  input  logic              dmReq,
  input  logic [ADDR_W-1:0] dmAddr,
  output logic              pmIntSel,
  output logic              pmExtSel,
  output logic [ADDR_W-1:0] pmExtAddr,
  output logic              dmIntSel,
  output logic              dmRegSel,
  output logic              dmExtSel,
  output logic [ADDR_W-1:0] dmExtAddr,
  output logic              ovlErr
);

  localparam int SEG_W = ADDR_W - 1;

  ovlSel_t pmOvl, dmOvl;

  // Overlay registers: hold value until rewritten
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pmOvl <= OVL_INTERNAL;
      dmOvl <= OVL_INTERNAL;
    end else begin
      if (strobe.pmWr) pmOvl <= strobe.val;
      if (strobe.dmWr) dmOvl <= strobe.val;
    end
  end

  logic pmBad, dmBad;
  logic pmUpper, dmUpper;
  logic pmUseExt, dmUseExt, dmInWin;
  logic pmBank, dmBank;

  always_comb begin
    pmBad   = (pmOvl == OVL_INVALID) || (compatMode && pmOvl != OVL_INTERNAL);
    dmBad   = (dmOvl == OVL_INVALID);
    pmUpper = pmAddr[ADDR_W-1];
    dmUpper = dmAddr[ADDR_W-1];

    // Program space
    if (compatMode) begin
      pmUseExt = !pmUpper;
      pmBank   = 1'b0;
    end else begin
      pmUseExt = pmUpper && !pmBad && (pmOvl != OVL_INTERNAL);
      pmBank   = (pmOvl == OVL_SEG_HI);
    end

    // Data space
    dmInWin  = dmUpper && (&dmAddr[ADDR_W-2:REG_WIN_W]);
    dmUseExt = !dmUpper && !dmBad && (dmOvl != OVL_INTERNAL);
    dmBank   = (dmOvl == OVL_SEG_HI);

    pmIntSel  = pmReq && !pmUseExt;
    pmExtSel  = pmReq && pmUseExt;
    pmExtAddr = pmExtSel ? {pmBank, pmAddr[SEG_W-1:0]} : '0;

    dmRegSel  = dmReq && dmInWin;
    dmExtSel  = dmReq && dmUseExt;
    dmIntSel  = dmReq && !dmUseExt && !dmInWin;
    dmExtAddr = dmExtSel ? {dmBank, dmAddr[SEG_W-1:0]} : '0;

    ovlErr = pmBad || dmBad;
  end

endmodule

// File: rtl/ovl_addr_decoder.sv
module ovl_addr_decoder
  import ovl_dec_pkg::*;
#(
  parameter int ADDR_W    = 14,
  parameter int REG_WIN_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              compatMode,
  input  logic              ovlWrEn,
  input  logic              ovlWrSel,
  input  logic [1:0]        ovlWrData,
  input  logic              pmReq,
  input  logic [ADDR_W-1:0] pmAddr,
  input  logic              dmReq,
  input  logic [ADDR_W-1:0] dmAddr,
  output logic              pmIntSel,
  output logic              pmExtSel,
  output logic [ADDR_W-1:0] pmExtAddr,
  output logic              dmIntSel,
  output logic              dmRegSel,
  output logic              dmExtSel,
  output logic [ADDR_W-1:0] dmExtAddr,
  output logic              ovlErr
);

  ovlStrobe_t strobe;

  ovl_wr_ctrl u_ctrl (
    .ovlWrEn  (ovlWrEn),
    .ovlWrSel (ovlWrSel),
    .ovlWrData(ovlWrData),
    .strobe   (strobe)
  );

  ovl_decode_dp #(.ADDR_W(ADDR_W), .REG_WIN_W(REG_WIN_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .compatMode(compatMode),
    .pmReq     (pmReq),
    .pmAddr    (pmAddr),
    .dmReq     (dmReq),
    .dmAddr    (dmAddr),
    .pmIntSel  (pmIntSel),
    .pmExtSel  (pmExtSel),
    .pmExtAddr (pmExtAddr),
    .dmIntSel  (dmIntSel),
    .dmRegSel  (dmRegSel),
    .dmExtSel  (dmExtSel),
    .dmExtAddr (dmExtAddr),
    .ovlErr    (ovlErr)
  );

endmodule

// File: rtl/ovl_dec_checker.sv
module ovl_dec_checker #(
  parameter int ADDR_W    = 14,
  parameter int REG_WIN_W = 5
) (
  input logic              clk,
  input logic              rstN,
  input logic              compatMode,
  input logic              ovlWrEn,
  input logic              ovlWrSel,
  input logic [1:0]        ovlWrData,
  input logic              pmReq,
  input logic [ADDR_W-1:0] pmAddr,
  input logic              dmReq,
  input logic [ADDR_W-1:0] dmAddr,
  input logic              pmIntSel,
  input logic              pmExtSel,
  input logic [ADDR_W-1:0] pmExtAddr,
  input logic              dmIntSel,
  input logic              dmRegSel,
  input logic              dmExtSel,
  input logic [ADDR_W-1:0] dmExtAddr,
  input logic              ovlErr
);

  localparam int SEG_W = ADDR_W - 1;

  assert_pm_sel_excl_R9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({pmIntSel, pmExtSel}));

  assert_dm_sel_excl_R9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({dmIntSel, dmRegSel, dmExtSel}));

  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!pmReq |-> !(pmIntSel || pmExtSel)) and (!dmReq |-> !(dmIntSel || dmRegSel || dmExtSel)));

  assert_pm_ext_range_R2: assert property (@(posedge clk) disable iff (!rstN)
    (pmExtSel && !compatMode) |-> pmAddr[ADDR_W-1]);

  assert_dm_ext_range_R5: assert property (@(posedge clk) disable iff (!rstN)
    dmExtSel |-> !dmAddr[ADDR_W-1]);

  assert_reg_window_R4: assert property (@(posedge clk) disable iff (!rstN)
    dmRegSel |-> (&dmAddr[ADDR_W-1:REG_WIN_W]));

  assert_low_bits_pass_R3: assert property (@(posedge clk) disable iff (!rstN)
    (pmExtSel |-> pmExtAddr[SEG_W-1:0] == pmAddr[SEG_W-1:0]) and
    (dmExtSel |-> dmExtAddr[SEG_W-1:0] == dmAddr[SEG_W-1:0]));

  assert_compat_lower_R6: assert property (@(posedge clk) disable iff (!rstN)
    (compatMode && pmReq && !pmAddr[ADDR_W-1]) |-> (pmExtSel && !pmExtAddr[ADDR_W-1]));

  assert_write_next_edge_R8: assert property (@(posedge clk) disable iff (!rstN)
    (ovlWrEn && !ovlWrSel && ovlWrData == 2'd1) |=>
      (!(pmReq && pmAddr[ADDR_W-1] && !compatMode) || (pmExtSel && !pmExtAddr[ADDR_W-1])));

  assert_err_stable_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(ovlWrEn) && $stable(compatMode) && $past(rstN)) |-> $stable(ovlErr));

endmodule

bind ovl_addr_decoder ovl_dec_checker #(.ADDR_W(ADDR_W), .REG_WIN_W(REG_WIN_W)) u_chk (.*);

// File: tb/tb_ovl_addr_decoder.sv
module tb_ovl_addr_decoder;

  typedef struct packed {
    logic        pmI;
    logic        pmE;
    logic [13:0] pmA;
    logic        dmI;
    logic        dmR;
    logic        dmE;
    logic [13:0] dmA;
    logic        err;
  } expect_t;

  localparam logic [13:0] ADDRS [6] = '{14'h0000, 14'h1FFF, 14'h2000, 14'h3FDF, 14'h3FE0, 14'h3FFF};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic compatMode = 1'b0, ovlWrEn = 1'b0, ovlWrSel = 1'b0;
  logic [1:0] ovlWrData = 2'd0;
  logic pmReq = 1'b0, dmReq = 1'b0;
  logic [13:0] pmAddr = '0, dmAddr = '0;
  logic pmIntSel, pmExtSel, dmIntSel, dmRegSel, dmExtSel, ovlErr;
  logic [13:0] pmExtAddr, dmExtAddr;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  ovl_addr_decoder dut (.*);

  // Reference from the requirements
  function automatic expect_t refDecode(logic m, logic [1:0] pov, logic [1:0] dov,
                                        logic [13:0] pa, logic [13:0] da);
    expect_t e = '0;
    e.err = (pov == 2'd3) || (dov == 2'd3) || (m && pov != 2'd0);
    if (m) begin
      if (pa < 14'h2000) begin e.pmE = 1'b1; e.pmA = {1'b0, pa[12:0]}; end
      else e.pmI = 1'b1;
    end else if (pa >= 14'h2000 && (pov == 2'd1 || pov == 2'd2)) begin
      e.pmE = 1'b1; e.pmA = {pov == 2'd2, pa[12:0]};
    end else e.pmI = 1'b1;
    if (da >= 14'h3FE0) e.dmR = 1'b1;
    else if (da >= 14'h2000) e.dmI = 1'b1;
    else if (dov == 2'd1 || dov == 2'd2) begin e.dmE = 1'b1; e.dmA = {dov == 2'd2, da[12:0]}; end
    else e.dmI = 1'b1;
    return e;
  endfunction

  task automatic cmp(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic setOvl(logic sel, logic [1:0] v);
    @(negedge clk);
    ovlWrEn = 1'b1; ovlWrSel = sel; ovlWrData = v;
    @(negedge clk);
    ovlWrEn = 1'b0;
  endtask

  task automatic checkAt(logic m, logic [1:0] pov, logic [1:0] dov, logic [13:0] a,
                         string pmTag, string dmTag);
    expect_t e;
    @(negedge clk);
    compatMode = m; pmReq = 1'b1; dmReq = 1'b1; pmAddr = a; dmAddr = a;
    #1;
    e = refDecode(m, pov, dov, a, a);
    cmp(pmTag, {16'd0, pmIntSel, pmExtSel, pmExtAddr}, {16'd0, e.pmI, e.pmE, e.pmA});
    cmp(dmTag, {15'd0, dmIntSel, dmRegSel, dmExtSel, dmExtAddr},
        {15'd0, e.dmI, e.dmR, e.dmE, e.dmA});
    cmp("R7 ovlErr", {31'd0, ovlErr}, {31'd0, e.err});
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: reset state
    checkAt(1'b0, 2'd0, 2'd0, 14'h2000, "R1 pm after reset", "R1 dm after reset");
    checkAt(1'b0, 2'd0, 2'd0, 14'h0000, "R1 pm after reset", "R1 dm after reset");

    // Sweep of boundary table: R2 R3 R4 R5 R6 R7
    for (int m = 0; m < 2; m++)
      for (int p = 0; p < 4; p++)
        for (int d = 0; d < 4; d++) begin
          @(negedge clk); compatMode = m[0];
          setOvl(1'b0, p[1:0]);
          setOvl(1'b1, d[1:0]);
          for (int i = 0; i < 6; i++)
            checkAt(m[0], p[1:0], d[1:0], ADDRS[i],
                    m[0] ? "R6/R3 pm decode" : "R2/R3 pm decode",
                    ADDRS[i][13] ? "R4 dm decode" : "R5/R3 dm decode");
        end

    // R8: same-cycle write uses old value
    @(negedge clk); compatMode = 1'b0;
    setOvl(1'b0, 2'd0);
    setOvl(1'b1, 2'd0);
    @(negedge clk);
    pmReq = 1'b1; pmAddr = 14'h2ABC;
    ovlWrEn = 1'b1; ovlWrSel = 1'b0; ovlWrData = 2'd2;
    #1;
    cmp("R8 old value in write cycle", {31'd0, pmExtSel}, 32'd0);
    @(posedge clk); #1;
    ovlWrEn = 1'b0;
    cmp("R8 new value next edge sel", {31'd0, pmExtSel}, 32'd1);
    cmp("R8 new value next edge addr", {18'd0, pmExtAddr}, {18'd0, 14'h2ABC});

    // R10: other register untouched
    setOvl(1'b1, 2'd2);
    setOvl(1'b0, 2'd1);
    setOvl(1'b0, 2'd0);
    checkAt(1'b0, 2'd0, 2'd2, 14'h0123, "R10 pm after rewrite", "R10 dm kept");

    // R9: no request, no selects
    @(negedge clk); pmReq = 1'b0; dmReq = 1'b0; #1;
    cmp("R9 idle pm", {30'd0, pmIntSel, pmExtSel}, 32'd0);
    cmp("R9 idle dm", {29'd0, dmIntSel, dmRegSel, dmExtSel}, 32'd0);

    // R1: reset restores zero after nonzero values
    setOvl(1'b0, 2'd3);
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); rstN = 1'b1;
    checkAt(1'b0, 2'd0, 2'd0, 14'h3000, "R1 pm after rerun reset", "R1 dm after rerun reset");
    checkAt(1'b0, 2'd0, 2'd0, 14'h0800, "R1 pm after rerun reset", "R1 dm after rerun reset");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule